// File: doc/BRIEF.md
# TDM Framing Bit Pattern Generator

This block supplies the framing bit carried in the first bit of every 8-bit envelope on a 64 kbit/s time-division bearer. A strobe from the surrounding multiplexer marks the start of each envelope. On that strobe the block advances its envelope index and presents the framing bit for the envelope just begun. Index and bit are then held until the next strobe. Two frame lengths are offered: a long frame of 80 envelopes and a short frame of 20 envelopes. The frame length is chosen by a mode input that is sampled only when a frame begins.

Each frame length has its own maximal-length shift-register sequence, restarted from a fixed seed at every frame start. In the long frame, the first position of each group of ten envelopes is replaced. The first of these carries the alarm bit and the other seven carry fixed housekeeping values. In the short frame, only the first position is replaced, by the alarm bit. A one-clock frame-start pulse marks the strobe that opens envelope 0.

The framing bit is a control-rate signal paced by the strobe, so it is a plain output and not a valid/ready stream. The block never stalls and has no back-pressure. A consumer that needs the bit latches it on or after the strobe, and it stays valid until the next strobe.

Top module: `tdm_frame_gen`

## Requirements
- R1: After reset, `env_idx_o` is 0, `fbit_o` is 1 and `frame_start_o` is low while no strobe is present. The first strobe after reset begins envelope 0 of a new frame.
- R2: `env_idx_o` and `fbit_o` change only on a clock edge where `env_stb_i` is high. Between strobes they hold their values, and `frame_start_o` stays low.
- R3: In long mode (`short_mode_i` = 0 when the frame began), successive strobes give indices 0, 1, ... 79, and the strobe after index 79 gives 0.
- R4: In short mode (`short_mode_i` = 1 when the frame began), indices run 0 to 19 and then wrap to 0.
- R5: `frame_start_o` is high exactly during the clock cycle in which `env_stb_i` is high and that strobe begins envelope 0. It is low in every other cycle.
- R6: At envelope 0 in either mode, `fbit_o` equals the inverse of `alarm_i` as sampled on the opening strobe (1 means no alarm, 0 means alarm). It holds that value for the whole envelope.
- R7: In long mode, envelopes 10, 20, 30, 40, 50, 60 and 70 carry the fixed bits 1, 1, 0, 0, 1, 1, 0, in that order.
- R8: In long mode, every other envelope p carries u[p]. Here u[0..6] = 1,0,0,1,1,0,1 (the seed 1001101, leftmost bit first), and u[n+7] = u[n] xor u[n+3].
- R9: In short mode, envelopes 1 to 19 carry v[p]. Here v[0..4] = 0,1,1,1,0 (the seed 01110, leftmost bit first), and v[n+5] = v[n] xor v[n+2].
- R10: A change of `short_mode_i` during a frame does not affect that frame. The new length and pattern take effect from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| env_stb_i | input | 1 | One-clock strobe marking the start of an envelope |
| short_mode_i | input | 1 | 0 selects the 80-envelope frame, 1 selects the 20-envelope frame; sampled at frame start |
| alarm_i | input | 1 | Local alarm flag, 1 = alarm present |
| fbit_o | output | 1 | Framing bit of the current envelope |
| frame_start_o | output | 1 | High during the strobe cycle that begins envelope 0 |
| env_idx_o | output | 7 | Index of the current envelope within the frame |

## Verification
The bench builds the block with its default parameters: ten-envelope groups, eight long groups, a 20-envelope short frame, and the degree-7 and degree-5 generators. These values are small enough that every envelope of several complete frames of both lengths is compared against sequences the bench derives from the recurrences. The sweep varies the idle gap between strobes, changes the alarm within and across frames, and changes the mode in the middle of long and short frames. It therefore reaches the deferred mode switch, both wrap points, and all seven fixed housekeeping positions.

// File: rtl/tdmfr_pkg.sv
package tdmfr_pkg;

  typedef enum logic {
    FRM_LONG  = 1'b0,
    FRM_SHORT = 1'b1
  } frm_mode_e;

endpackage

// File: rtl/tdmfr_lfsr.sv
module tdmfr_lfsr #(
  parameter int unsigned    DEG  = 7,
  parameter int unsigned    TAP  = 3,
  parameter logic [DEG-1:0] SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic reload_i,
  output logic bit_o
);

  logic [DEG-1:0] state_q;

  function automatic logic [DEG-1:0] advance(input logic [DEG-1:0] s);
    return {s[DEG-2:0], s[DEG-1] ^ s[DEG-1-TAP]};
  endfunction

  // The oldest sequence element sits in the MSB. A reload restarts
  // the sequence, and element 0 is consumed by the opening envelope.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
    end else if (step_i) begin
      if (reload_i) state_q <= advance(SEED);
      else          state_q <= advance(state_q);
    end
  end

  assign bit_o = state_q[DEG-1];

endmodule

// File: rtl/tdmfr_envcnt.sv
module tdmfr_envcnt
  import tdmfr_pkg::*;
#(
  parameter int unsigned LONG_LEN  = 80,
  parameter int unsigned SHORT_LEN = 20,
  parameter int unsigned GROUP_LEN = 10,
  parameter int unsigned GROUPS    = 8,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned SLOT_W    = 4,
  parameter int unsigned GRP_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              short_mode_i,
  output logic              wrap_o,
  output logic [IDX_W-1:0]  pos_o,
  output logic [IDX_W-1:0]  nxt_pos_o,
  output logic [SLOT_W-1:0] nxt_slot_o,
  output logic [GRP_W-1:0]  nxt_grp_o,
  output frm_mode_e         nxt_mode_o
);

  logic              first_q;
  logic [IDX_W-1:0]  pos_q;
  logic [SLOT_W-1:0] slot_q;
  logic [GRP_W-1:0]  grp_q;
  frm_mode_e         mode_q;
  logic [IDX_W-1:0]  last_pos;
  logic              slot_end;

  assign last_pos = (mode_q == FRM_SHORT) ? IDX_W'(SHORT_LEN - 1) : IDX_W'(LONG_LEN - 1);
  assign wrap_o   = first_q | (pos_q == last_pos);
  assign slot_end = (slot_q == SLOT_W'(GROUP_LEN - 1));

  always_comb begin
    if (wrap_o) begin
      nxt_pos_o  = '0;
      nxt_slot_o = '0;
      nxt_grp_o  = '0;
      nxt_mode_o = short_mode_i ? FRM_SHORT : FRM_LONG;
    end else begin
      nxt_pos_o  = pos_q + IDX_W'(1);
      nxt_slot_o = slot_end ? '0 : slot_q + SLOT_W'(1);
      nxt_grp_o  = slot_end ? grp_q + GRP_W'(1) : grp_q;
      nxt_mode_o = mode_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      pos_q   <= '0;
      slot_q  <= '0;
      grp_q   <= '0;
      mode_q  <= FRM_LONG;
    end else if (stb_i) begin
      first_q <= 1'b0;
      pos_q   <= nxt_pos_o;
      slot_q  <= nxt_slot_o;
      grp_q   <= nxt_grp_o;
      mode_q  <= nxt_mode_o;
    end
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/tdmfr_bitsel.sv
module tdmfr_bitsel
  import tdmfr_pkg::*;
#(
  parameter int unsigned       GROUPS  = 8,
  parameter int unsigned       IDX_W   = 7,
  parameter int unsigned       SLOT_W  = 4,
  parameter int unsigned       GRP_W   = 3,
  parameter logic [GROUPS-2:0] HK_BITS = '0
) (
  input  logic [IDX_W-1:0]  pos_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  frm_mode_e         mode_i,
  input  logic              alarm_i,
  input  logic [1:0]        seq_bits_i,
  output logic              bit_o
);

  // Group 0 is the alarm slot, so the table is padded at index 0 position
  // by shifting: entry g-1 holds the bit of group g.
  localparam logic [GROUPS-1:0] HK_TABLE = {1'b1, HK_BITS};

  logic [GRP_W-1:0] hk_idx;
  assign hk_idx = grp_i - GRP_W'(1);

  always_comb begin
    if (pos_i == '0) begin
      bit_o = ~alarm_i;
    end else if (mode_i == FRM_LONG && slot_i == '0) begin
      bit_o = HK_TABLE[hk_idx];
    end else if (mode_i == FRM_LONG) begin
      bit_o = seq_bits_i[0];
    end else begin
      bit_o = seq_bits_i[1];
    end
  end

endmodule

// File: rtl/tdm_frame_gen.sv
module tdm_frame_gen
  import tdmfr_pkg::*;
#(
  parameter int unsigned           LONG_GROUPS = 8,
  parameter int unsigned           GROUP_LEN   = 10,
  parameter int unsigned           SHORT_LEN   = 20,
  parameter int unsigned           LONG_DEG    = 7,
  parameter int unsigned           LONG_TAP    = 3,
  parameter logic [LONG_DEG-1:0]   LONG_SEED   = 7'b1001101,
  parameter int unsigned           SHORT_DEG   = 5,
  parameter int unsigned           SHORT_TAP   = 2,
  parameter logic [SHORT_DEG-1:0]  SHORT_SEED  = 5'b01110,
  parameter logic [LONG_GROUPS-2:0] HK_BITS    = 7'b0110011
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       env_stb_i,
  input  logic       short_mode_i,
  input  logic       alarm_i,
  output logic       fbit_o,
  output logic       frame_start_o,
  output logic [6:0] env_idx_o
);

  localparam int unsigned LONG_LEN = LONG_GROUPS * GROUP_LEN;
  localparam int unsigned IDX_W    = $clog2(LONG_LEN);
  localparam int unsigned SLOT_W   = $clog2(GROUP_LEN);
  localparam int unsigned GRP_W    = $clog2(LONG_GROUPS);

  logic              wrap;
  logic [IDX_W-1:0]  pos;
  logic [IDX_W-1:0]  nxt_pos;
  logic [SLOT_W-1:0] nxt_slot;
  logic [GRP_W-1:0]  nxt_grp;
  frm_mode_e         nxt_mode;
  logic [1:0]        seq_bits;
  logic              sel_bit;
  logic              fbit_q;

  tdmfr_envcnt #(
    .LONG_LEN (LONG_LEN),
    .SHORT_LEN(SHORT_LEN),
    .GROUP_LEN(GROUP_LEN),
    .GROUPS   (LONG_GROUPS),
    .IDX_W    (IDX_W),
    .SLOT_W   (SLOT_W),
    .GRP_W    (GRP_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (env_stb_i),
    .short_mode_i(short_mode_i),
    .wrap_o      (wrap),
    .pos_o       (pos),
    .nxt_pos_o   (nxt_pos),
    .nxt_slot_o  (nxt_slot),
    .nxt_grp_o   (nxt_grp),
    .nxt_mode_o  (nxt_mode)
  );

  // One generator per frame length; index 0 long, index 1 short.
  for (genvar g = 0; g < 2; g++) begin : g_seq
    if (g == 0) begin : g_long
      tdmfr_lfsr #(.DEG(LONG_DEG), .TAP(LONG_TAP), .SEED(LONG_SEED)) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (env_stb_i),
        .reload_i(wrap),
        .bit_o   (seq_bits[g])
      );
    end else begin : g_short
      tdmfr_lfsr #(.DEG(SHORT_DEG), .TAP(SHORT_TAP), .SEED(SHORT_SEED)) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (env_stb_i),
        .reload_i(wrap),
        .bit_o   (seq_bits[g])
      );
    end
  end

  tdmfr_bitsel #(
    .GROUPS (LONG_GROUPS),
    .IDX_W  (IDX_W),
    .SLOT_W (SLOT_W),
    .GRP_W  (GRP_W),
    .HK_BITS(HK_BITS)
  ) u_sel (
    .pos_i     (nxt_pos),
    .slot_i    (nxt_slot),
    .grp_i     (nxt_grp),
    .mode_i    (nxt_mode),
    .alarm_i   (alarm_i),
    .seq_bits_i(seq_bits),
    .bit_o     (sel_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fbit_q <= 1'b1;
    else if (env_stb_i) fbit_q <= sel_bit;
  end

  assign fbit_o        = fbit_q;
  assign frame_start_o = env_stb_i & wrap;
  assign env_idx_o     = 7'(pos);

endmodule

// File: rtl/tdmfr_check.sv
module tdmfr_check #(
  parameter int unsigned LONG_LEN = 80
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       env_stb_i,
  input logic       alarm_i,
  input logic       fbit_o,
  input logic       frame_start_o,
  input logic [6:0] env_idx_o
);

  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !env_stb_i |=> $stable(env_idx_o) && $stable(fbit_o)); // R2

  AST_START_WITH_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> env_stb_i); // R5

  AST_START_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> env_idx_o == 7'd0); // R5

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    env_stb_i && !frame_start_o |=> env_idx_o == $past(env_idx_o) + 7'd1); // R3

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    env_idx_o < 7'(LONG_LEN)); // R3

  AST_ALARM_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> fbit_o == !$past(alarm_i)); // R6

endmodule

bind tdm_frame_gen tdmfr_check #(.LONG_LEN(LONG_LEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .env_stb_i    (env_stb_i),
  .alarm_i      (alarm_i),
  .fbit_o       (fbit_o),
  .frame_start_o(frame_start_o),
  .env_idx_o    (env_idx_o)
);

// File: tb/tb_tdm_frame_gen.sv
module tb_tdm_frame_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       env_stb = 1'b0;
  logic       short_mode = 1'b0;
  logic       alarm = 1'b0;
  logic       fbit;
  logic       frame_start;
  logic [6:0] env_idx;

  int checks = 0;
  int failures = 0;

  logic lu [0:79];
  logic su [0:19];
  logic [6:0] hk_exp = 7'b0110011; // bit g-1 is the value of group g (R7)

  int   b_pos;
  logic b_mode;
  logic b_first;
  logic e_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_frame_gen dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .env_stb_i    (env_stb),
    .short_mode_i (short_mode),
    .alarm_i      (alarm),
    .fbit_o       (fbit),
    .frame_start_o(frame_start),
    .env_idx_o    (env_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input int pos, input logic mode, input logic alm);
    if (pos == 0)                      return !alm;
    if (!mode && (pos % 10) == 0)      return hk_exp[pos/10 - 1];
    if (!mode)                         return lu[pos];
    return su[pos];
  endfunction

  function automatic string bit_tag(input int pos, input logic mode);
    if (pos == 0)                 return "R6";
    if (!mode && (pos % 10) == 0) return "R7";
    if (!mode)                    return "R8";
    return "R9";
  endfunction

  task automatic strobe(input int gap, input logic mode_v, input logic alarm_v);
    logic wrap;
    string itag;
    @(negedge clk);
    short_mode = mode_v;
    alarm = alarm_v;
    env_stb = 1'b1;
    #1;
    wrap = b_first || (b_pos == (b_mode ? 19 : 79));
    chk(frame_start == wrap, "R5 frame_start", int'(frame_start), int'(wrap));
    itag = b_mode ? "R4 index" : "R3 index";
    if (!wrap && mode_v != b_mode) itag = "R10 index";
    if (wrap) begin
      b_pos = 0; b_mode = mode_v; b_first = 1'b0;
    end else begin
      b_pos++;
    end
    e_bit = exp_bit(b_pos, b_mode, alarm_v);
    @(negedge clk);
    env_stb = 1'b0;
    chk(int'(env_idx) == b_pos, itag, int'(env_idx), b_pos);
    chk(fbit == e_bit, bit_tag(b_pos, b_mode), int'(fbit), int'(e_bit));
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      alarm = ~alarm;
      short_mode = ~short_mode;
      chk(int'(env_idx) == b_pos && fbit == e_bit && !frame_start,
          "R2 hold", int'(env_idx), b_pos);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    lu[0] = 1; lu[1] = 0; lu[2] = 0; lu[3] = 1; lu[4] = 1; lu[5] = 0; lu[6] = 1;
    for (int n = 7; n < 80; n++) lu[n] = lu[n-7] ^ lu[n-4];
    su[0] = 0; su[1] = 1; su[2] = 1; su[3] = 1; su[4] = 0;
    for (int n = 5; n < 20; n++) su[n] = su[n-5] ^ su[n-3];
    b_pos = 0; b_mode = 1'b0; b_first = 1'b1;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(env_idx == 7'd0, "R1 idx", int'(env_idx), 0);
    chk(fbit == 1'b1, "R1 fbit", int'(fbit), 1);
    chk(frame_start == 1'b0, "R1 frame_start", int'(frame_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(env_idx == 7'd0 && fbit == 1'b1, "R1 after release", int'(env_idx), 0);

    // Long frame with alarm present, then long frame without alarm.
    for (int i = 0; i < 80; i++) strobe(i % 3, 1'b0, i == 0);
    for (int i = 0; i < 80; i++) strobe((i + 1) % 3, i >= 40, i == 5); // R10 switch mid-frame
    // Short frames with varying alarm.
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 20; i++) strobe((i + f) % 3, !(f == 2 && i >= 10), (i + f) % 2 == 0);
    // Back to a long frame, then a short one requested mid long frame.
    for (int i = 0; i < 80; i++) strobe(i % 2, i >= 70, 1'b0);
    for (int i = 0; i < 25; i++) strobe(1, 1'b1, 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule